// File: doc/BRIEF.md
# Surface Load Coordinate Address Unit

This unit turns one surface load request into a pitch-linear byte address, or into a zero-return or fault outcome. A request carries up to three coordinate words, a dimension code, a raw-or-formatted mode bit, a raw access size, a byte-address flag, a clamp policy and a 32-bit descriptor handle. The unit takes the header index from the handle and checks it against a configured limit. It reads each coordinate by the rules of the dimension, checks it against the surface extents and applies the clamp policy. It then scales x to bytes and adds the strided terms to the surface base.

The first stage decodes, range-checks and clamps. The second stage does the multiply-add. Requests enter and results leave through valid/ready handshakes. With no back-pressure, a result appears exactly two cycles after its request is accepted. Configuration inputs are expected to stay constant while requests are in flight.

Top module: `surf_coord_addr`

## Requirements
- R1: A request accepted in cycle t (req_valid and req_ready high) gives rsp_valid in cycle t+2 when rsp_ready is high in cycle t+1. req_ready is low only while a response is held with rsp_ready low. A held response keeps its address and flags unchanged.
- R2: The header index is handle bits [19:0], and bits [31:20] are ignored. An index above cfg_max_index, or cfg_enable low, gives rsp_zero=1 and rsp_fault=0 whatever the other fields hold.
- R3: Dimension codes: 0=1D, 1=1D buffer, 2=1D array, 3=2D, 4=2D array, 5=3D (6 and 7 act as 1D). y comes from req_y for codes 3, 4 and 5. z comes from req_z for code 5. Any coordinate the dimension does not use contributes 0.
- R4: The layer index is req_y[15:0] for code 2 and req_z[15:0] for code 4. It is read as unsigned, so the upper 16 bits have no effect.
- R5: For the 1D buffer, x is signed when clamp is NEAR and unsigned in any other clamp mode. Every other x, y and z is signed 32-bit.
- R6: Clamp codes are 0=IGN, 1=NEAR and 2=TRAP (3 acts as TRAP). Under NEAR, a coordinate below 0 becomes 0 and one at or above its extent becomes extent-1.
- R7: Under IGN, any out-of-range coordinate gives rsp_zero=1 with rsp_addr=0.
- R8: Under TRAP, any out-of-range coordinate gives rsp_fault=1 with rsp_addr=0. An in-range TRAP request produces its normal address.
- R9: In raw mode (req_fmt=0) without the byte-address flag, x is multiplied by 2^req_size bytes: size codes 0..4 select 1, 2, 4, 8 and 16 bytes, and codes 5..7 select 16.
- R10: In raw mode with req_byte_addr=1, x is a byte offset. If x is not a multiple of the access size, rsp_fault=1, and this takes priority over the clamp policy. The range check and clamp apply to x divided by the access size.
- R11: In formatted mode (req_fmt=1), x is scaled by 2^cfg_pixel_log2, and req_byte_addr and req_size have no effect.
- R12: rsp_addr = cfg_base + layer*cfg_layer_stride + z*cfg_slice_stride + y*cfg_pitch + x_bytes, modulo 2^AW. rsp_zero and rsp_fault are never both high, and either one forces rsp_addr to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_x | input | CW | First coordinate word |
| req_y | input | CW | Second coordinate word (y or layer) |
| req_z | input | CW | Third coordinate word (z or layer) |
| req_dim | input | 3 | Dimension code |
| req_fmt | input | 1 | 0 raw, 1 formatted |
| req_size | input | 3 | Raw access size as log2 bytes |
| req_byte_addr | input | 1 | x given in bytes (raw mode) |
| req_clamp | input | 2 | Clamp policy code |
| req_handle | input | 32 | Packed descriptor handle |
| cfg_enable | input | 1 | Surface enabled |
| cfg_max_index | input | IW | Largest valid header index |
| cfg_base | input | AW | Surface base byte address |
| cfg_pitch | input | AW | Bytes per row |
| cfg_slice_stride | input | AW | Bytes per z slice |
| cfg_layer_stride | input | AW | Bytes per array layer |
| cfg_width | input | SW | Extent in x samples |
| cfg_height | input | SW | Extent in y |
| cfg_depth | input | SW | Extent in z |
| cfg_layers | input | SW | Number of array layers |
| cfg_pixel_log2 | input | 3 | log2 bytes per formatted sample |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken when high with rsp_valid |
| rsp_addr | output | AW | Byte address, 0 when zero or fault |
| rsp_zero | output | 1 | No access, data returns as zero |
| rsp_fault | output | 1 | Access suppressed with a fault |

## Verification
The assertions check the timing and exclusivity rules on every cycle. These are the two-cycle latency, the hold of a stalled response, ready being low only under back-pressure, the zero result for an out-of-limit header index, and the rules that zero and fault never coincide and that either one forces the address to 0. The bench scenarios are what show the per-dimension selection of coordinates, the 16-bit unsigned layer index, the sign rule for the 1D buffer and each clamp policy at both edges. They also cover the alignment-fault priority in byte mode and the scaling in both raw and formatted modes, since those need expected addresses worked out by hand.

// File: rtl/surf_addr_pkg.sv
package surf_addr_pkg;
  typedef enum logic [2:0] {
    DIM_1D      = 3'd0,
    DIM_1D_BUF  = 3'd1,
    DIM_1D_ARR  = 3'd2,
    DIM_2D      = 3'd3,
    DIM_2D_ARR  = 3'd4,
    DIM_3D      = 3'd5
  } dim_e;

  typedef enum logic [1:0] {
    CLAMP_IGN  = 2'd0,
    CLAMP_NEAR = 2'd1,
    CLAMP_TRAP = 2'd2
  } clamp_e;

  typedef enum logic [1:0] {
    RES_ACCESS = 2'd0,
    RES_ZERO   = 2'd1,
    RES_FAULT  = 2'd2
  } result_e;

  localparam int NUM_COORDS = 4;  // x, y, z, layer
  localparam int SHIFT_W    = 3;
endpackage

// File: rtl/surf_coord_clamp.sv
module surf_coord_clamp #(
  parameter int CW = 32,
  parameter int SW = 16
) (
  input  logic [CW-1:0] raw,
  input  logic          is_signed,
  input  logic          used,
  input  logic [SW-1:0] extent,
  output logic          too_low,
  output logic          too_high,
  output logic [SW-1:0] near_val
);
  logic          neg;
  logic [CW-1:0] lim;

  always_comb begin
    neg      = is_signed & raw[CW-1];
    lim      = CW'(extent);
    too_low  = used & neg;
    too_high = used & ~neg & (raw >= lim);
    if (!used || too_low) near_val = '0;
    else if (too_high)    near_val = extent - SW'(1);
    else                  near_val = raw[SW-1:0];
  end
endmodule

// File: rtl/surf_addr_calc.sv
module surf_addr_calc #(
  parameter int AW  = 40,
  parameter int SW  = 16,
  parameter int SHW = 3
) (
  input  logic [SW-1:0]  x_smp,
  input  logic [SW-1:0]  y_row,
  input  logic [SW-1:0]  z_slc,
  input  logic [SW-1:0]  layer,
  input  logic [SHW-1:0] shift,
  input  logic [AW-1:0]  base,
  input  logic [AW-1:0]  pitch,
  input  logic [AW-1:0]  slice_stride,
  input  logic [AW-1:0]  layer_stride,
  output logic [AW-1:0]  addr
);
  logic [AW-1:0] x_bytes;
  logic [AW-1:0] row_off;
  logic [AW-1:0] slc_off;
  logic [AW-1:0] lyr_off;

  always_comb begin
    x_bytes = AW'(x_smp) << shift;
    row_off = AW'(y_row) * pitch;
    slc_off = AW'(z_slc) * slice_stride;
    lyr_off = AW'(layer) * layer_stride;
    addr    = base + lyr_off + slc_off + row_off + x_bytes;
  end
endmodule

// File: rtl/surf_coord_addr.sv
module surf_coord_addr
  import surf_addr_pkg::*;
#(
  parameter int AW = 40,
  parameter int CW = 32,
  parameter int SW = 16,
  parameter int IW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [CW-1:0] req_x,
  input  logic [CW-1:0] req_y,
  input  logic [CW-1:0] req_z,
  input  logic [2:0]    req_dim,
  input  logic          req_fmt,
  input  logic [2:0]    req_size,
  input  logic          req_byte_addr,
  input  logic [1:0]    req_clamp,
  input  logic [31:0]   req_handle,
  input  logic          cfg_enable,
  input  logic [IW-1:0] cfg_max_index,
  input  logic [AW-1:0] cfg_base,
  input  logic [AW-1:0] cfg_pitch,
  input  logic [AW-1:0] cfg_slice_stride,
  input  logic [AW-1:0] cfg_layer_stride,
  input  logic [SW-1:0] cfg_width,
  input  logic [SW-1:0] cfg_height,
  input  logic [SW-1:0] cfg_depth,
  input  logic [SW-1:0] cfg_layers,
  input  logic [2:0]    cfg_pixel_log2,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [AW-1:0] rsp_addr,
  output logic          rsp_zero,
  output logic          rsp_fault
);
  localparam logic [SHIFT_W-1:0] MAX_SIZE = SHIFT_W'(4);
  localparam int                 LYR_W    = 16;

  logic unused_sampler;
  assign unused_sampler = ^req_handle[31:IW];

  // ---- stage 1 decode ----
  dim_e                dim;
  logic                near_m, ign_m, byte_m, x_signed, misalign, invalid, oor;
  logic [SHIFT_W-1:0]  eff_size, shift;
  logic [CW-1:0]       low_mask, x_samp, lyr_raw;
  logic [CW-1:0]       c_raw  [NUM_COORDS];
  logic                c_sgn  [NUM_COORDS];
  logic                c_use  [NUM_COORDS];
  logic [SW-1:0]       c_ext  [NUM_COORDS];
  logic                c_low  [NUM_COORDS];
  logic                c_high [NUM_COORDS];
  logic [SW-1:0]       c_near [NUM_COORDS];
  result_e             res_d;
  logic                adv;

  always_comb begin
    dim      = dim_e'(req_dim);
    near_m   = (req_clamp == CLAMP_NEAR);
    ign_m    = (req_clamp == CLAMP_IGN);
    eff_size = (req_size > MAX_SIZE) ? MAX_SIZE : req_size;
    shift    = req_fmt ? cfg_pixel_log2 : eff_size;
    byte_m   = ~req_fmt & req_byte_addr;
    x_signed = !((dim == DIM_1D_BUF) && !near_m);
    low_mask = (CW'(1) << shift) - CW'(1);
    misalign = byte_m && ((req_x & low_mask) != '0);
    if (!byte_m)       x_samp = req_x;
    else if (x_signed) x_samp = CW'($signed(req_x) >>> shift);
    else               x_samp = req_x >> shift;
    lyr_raw  = (dim == DIM_1D_ARR) ? CW'(req_y[LYR_W-1:0]) : CW'(req_z[LYR_W-1:0]);

    c_raw[0] = x_samp;  c_sgn[0] = x_signed; c_use[0] = 1'b1;   c_ext[0] = cfg_width;
    c_raw[1] = req_y;   c_sgn[1] = 1'b1;     c_ext[1] = cfg_height;
    c_use[1] = (dim == DIM_2D) || (dim == DIM_2D_ARR) || (dim == DIM_3D);
    c_raw[2] = req_z;   c_sgn[2] = 1'b1;     c_ext[2] = cfg_depth;
    c_use[2] = (dim == DIM_3D);
    c_raw[3] = lyr_raw; c_sgn[3] = 1'b0;     c_ext[3] = cfg_layers;
    c_use[3] = (dim == DIM_1D_ARR) || (dim == DIM_2D_ARR);
  end

  for (genvar g = 0; g < NUM_COORDS; g++) begin : g_crd
    surf_coord_clamp #(.CW(CW), .SW(SW)) u_clamp (
      .raw      (c_raw[g]),
      .is_signed(c_sgn[g]),
      .used     (c_use[g]),
      .extent   (c_ext[g]),
      .too_low  (c_low[g]),
      .too_high (c_high[g]),
      .near_val (c_near[g])
    );
  end

  always_comb begin
    oor = 1'b0;
    for (int i = 0; i < NUM_COORDS; i++) oor = oor | c_low[i] | c_high[i];
    invalid = (req_handle[IW-1:0] > cfg_max_index) || !cfg_enable;
    if (invalid)     res_d = RES_ZERO;
    else if (misalign) res_d = RES_FAULT;
    else if (!oor)   res_d = RES_ACCESS;
    else if (near_m) res_d = RES_ACCESS;
    else if (ign_m)  res_d = RES_ZERO;
    else             res_d = RES_FAULT;
  end

  // ---- pipeline state ----
  logic               s1_valid_q, s1_valid_d;
  result_e            s1_res_q;
  logic [SW-1:0]      s1_crd_q [NUM_COORDS];
  logic [SHIFT_W-1:0] s1_shift_q;
  logic               rsp_valid_q, rsp_valid_d;
  logic               rsp_zero_q, rsp_zero_d, rsp_fault_q, rsp_fault_d;
  logic [AW-1:0]      rsp_addr_q, rsp_addr_d, calc_addr;

  surf_addr_calc #(.AW(AW), .SW(SW), .SHW(SHIFT_W)) u_calc (
    .x_smp       (s1_crd_q[0]),
    .y_row       (s1_crd_q[1]),
    .z_slc       (s1_crd_q[2]),
    .layer       (s1_crd_q[3]),
    .shift       (s1_shift_q),
    .base        (cfg_base),
    .pitch       (cfg_pitch),
    .slice_stride(cfg_slice_stride),
    .layer_stride(cfg_layer_stride),
    .addr        (calc_addr)
  );

  always_comb begin
    adv         = !rsp_valid_q || rsp_ready;
    s1_valid_d  = adv ? req_valid : s1_valid_q;
    rsp_valid_d = adv ? s1_valid_q : rsp_valid_q;
    rsp_zero_d  = adv ? (s1_valid_q && s1_res_q == RES_ZERO)  : rsp_zero_q;
    rsp_fault_d = adv ? (s1_valid_q && s1_res_q == RES_FAULT) : rsp_fault_q;
    rsp_addr_d  = (s1_res_q == RES_ACCESS) ? calc_addr : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid_q  <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_zero_q  <= 1'b0;
      rsp_fault_q <= 1'b0;
    end else begin
      s1_valid_q  <= s1_valid_d;
      rsp_valid_q <= rsp_valid_d;
      rsp_zero_q  <= rsp_zero_d;
      rsp_fault_q <= rsp_fault_d;
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      s1_res_q   <= res_d;
      s1_shift_q <= shift;
      rsp_addr_q <= rsp_addr_d;
      for (int i = 0; i < NUM_COORDS; i++) s1_crd_q[i] <= c_near[i];
    end
  end

  assign req_ready = adv;
  assign rsp_valid = rsp_valid_q;
  assign rsp_addr  = rsp_addr_q;
  assign rsp_zero  = rsp_zero_q;
  assign rsp_fault = rsp_fault_q;
endmodule

// File: rtl/surf_coord_addr_chk.sv
module surf_coord_addr_chk #(
  parameter int AW = 40,
  parameter int IW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [IW-1:0] hdr_idx,
  input logic [IW-1:0] cfg_max_index,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [AW-1:0] rsp_addr,
  input logic          rsp_zero,
  input logic          rsp_fault
);
  // R1: two-cycle latency when the output can drain
  assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) ##1 (!rsp_valid || rsp_ready) |=> rsp_valid);

  // R1: a stalled response stays put
  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr)
                                   && $stable(rsp_zero) && $stable(rsp_fault)));

  // R1: input side blocks only under output back-pressure
  assert_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> (rsp_valid && !rsp_ready));

  // R2: header index above limit returns zero
  assert_bad_index_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (hdr_idx > cfg_max_index)) ##1 (!rsp_valid || rsp_ready)
      |=> (rsp_zero && !rsp_fault));

  // R12: zero and fault exclusive, either forces address 0
  assert_outcome_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(rsp_zero && rsp_fault));

  assert_addr_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (rsp_zero || rsp_fault)) |-> (rsp_addr == '0));
endmodule

bind surf_coord_addr surf_coord_addr_chk #(.AW(AW), .IW(IW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .hdr_idx      (req_handle[IW-1:0]),
  .cfg_max_index(cfg_max_index),
  .rsp_valid    (rsp_valid),
  .rsp_ready    (rsp_ready),
  .rsp_addr     (rsp_addr),
  .rsp_zero     (rsp_zero),
  .rsp_fault    (rsp_fault)
);

// File: tb/surf_coord_addr_tb.sv
`timescale 1ns/1ps
module surf_coord_addr_tb;
  localparam int AW = 40;
  localparam logic [AW-1:0] B  = 40'h00_1000_0000;
  localparam logic [AW-1:0] P  = 40'h400;
  localparam logic [AW-1:0] SS = 40'h1_0000;
  localparam logic [AW-1:0] LS = 40'h10_0000;
  localparam logic [31:0]   HOK = 32'h0000_0010;

  logic clk, rst_n;
  logic req_valid, req_ready, req_fmt, req_byte_addr;
  logic [31:0] req_x, req_y, req_z, req_handle;
  logic [2:0]  req_dim, req_size, cfg_pixel_log2;
  logic [1:0]  req_clamp;
  logic cfg_enable;
  logic [19:0] cfg_max_index;
  logic [AW-1:0] cfg_base, cfg_pitch, cfg_slice_stride, cfg_layer_stride;
  logic [15:0] cfg_width, cfg_height, cfg_depth, cfg_layers;
  logic rsp_valid, rsp_ready, rsp_zero, rsp_fault;
  logic [AW-1:0] rsp_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  surf_coord_addr u_dut (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] ea(input int l, input int z, input int y, input int xb);
    return B + AW'(l) * LS + AW'(z) * SS + AW'(y) * P + AW'(xb);
  endfunction

  // kind: 0 access, 1 zero, 2 fault
  task automatic run(input string tag, input logic [2:0] dim, input logic fmt,
                     input logic [2:0] sz, input logic ba, input logic [1:0] cl,
                     input logic [31:0] h, input logic [31:0] x, input logic [31:0] y,
                     input logic [31:0] z, input int kind, input logic [AW-1:0] exp);
    @(negedge clk);
    req_valid = 1; req_dim = dim; req_fmt = fmt; req_size = sz; req_byte_addr = ba;
    req_clamp = cl; req_handle = h; req_x = x; req_y = y; req_z = z;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    @(posedge clk);
    @(negedge clk);
    check({tag, " valid"}, 64'(rsp_valid), 64'd1);
    check({tag, " zero"},  64'(rsp_zero),  64'(kind == 1));
    check({tag, " fault"}, 64'(rsp_fault), 64'(kind == 2));
    check({tag, " addr"},  64'(rsp_addr),  64'(kind == 0 ? exp : '0));
  endtask

  task automatic t_reset();
    check("R1 reset valid", 64'(rsp_valid), 64'd0);
    check("R1 reset ready", 64'(req_ready), 64'd1);
  endtask

  task automatic t_dims();
    run("R3 R9 R12 2D", 3'd3, 0, 3'd2, 0, 2'd1, HOK, 3, 5, 0, 0, ea(0, 0, 5, 12));
    run("R3 R12 3D", 3'd5, 0, 3'd0, 0, 2'd1, HOK, 1, 2, 3, 0, ea(0, 3, 2, 1));
    run("R3 1D ignores y z", 3'd0, 0, 3'd2, 0, 2'd1, HOK, 7, 7, 9, 0, ea(0, 0, 0, 28));
    run("R3 code7 as 1D", 3'd7, 0, 3'd0, 0, 2'd1, HOK, 4, 3, 3, 0, ea(0, 0, 0, 4));
  endtask

  task automatic t_layers();
    run("R4 1D array low16", 3'd2, 0, 3'd2, 0, 2'd1, HOK, 1, 32'hFFFF_0002, 32'h55, 0, ea(2, 0, 0, 4));
    run("R4 2D array low16", 3'd4, 0, 3'd1, 0, 2'd1, HOK, 4, 6, 32'h0001_0003, 0, ea(3, 0, 6, 8));
    run("R4 R6 layer clamp", 3'd2, 0, 3'd0, 0, 2'd1, HOK, 0, 5, 0, 0, ea(3, 0, 0, 0));
  endtask

  task automatic t_clamp();
    run("R6 near both edges", 3'd3, 0, 3'd0, 0, 2'd1, HOK, 32'hFFFF_FFFB, 60, 0, 0, ea(0, 0, 49, 0));
    run("R5 buffer signed near", 3'd1, 0, 3'd0, 0, 2'd1, HOK, 32'hFFFF_FFFF, 0, 0, 0, ea(0, 0, 0, 0));
    run("R5 R8 buffer unsigned trap", 3'd1, 0, 3'd0, 0, 2'd2, HOK, 32'hFFFF_FFFF, 0, 0, 2, '0);
    run("R5 R7 buffer unsigned ign", 3'd1, 0, 3'd0, 0, 2'd0, HOK, 32'hFFFF_FFFF, 0, 0, 1, '0);
    run("R8 buffer in range trap", 3'd1, 0, 3'd0, 0, 2'd2, HOK, 50, 0, 0, 0, ea(0, 0, 0, 50));
    run("R7 ign x at width", 3'd3, 0, 3'd0, 0, 2'd0, HOK, 100, 0, 0, 1, '0);
    run("R8 trap z at depth", 3'd5, 0, 3'd0, 0, 2'd2, HOK, 0, 0, 8, 2, '0);
    run("R8 trap top corner ok", 3'd3, 0, 3'd0, 0, 2'd2, HOK, 99, 49, 0, 0, ea(0, 0, 49, 99));
    run("R8 code3 acts as trap", 3'd3, 0, 3'd0, 0, 2'd3, HOK, 0, 50, 0, 2, '0);
  endtask

  task automatic t_handle();
    run("R2 index over max", 3'd3, 0, 3'd0, 0, 2'd2, 32'h0000_0101, 500, 0, 0, 1, '0);
    run("R2 sampler ignored", 3'd3, 0, 3'd0, 0, 2'd1, 32'hABC0_0100, 1, 0, 0, 0, ea(0, 0, 0, 1));
    @(negedge clk); cfg_enable = 0;
    run("R2 disabled", 3'd3, 0, 3'd0, 0, 2'd1, HOK, 1, 1, 0, 1, '0);
    @(negedge clk); cfg_enable = 1;
  endtask

  task automatic t_byte_mode();
    run("R10 aligned bytes", 3'd0, 0, 3'd3, 1, 2'd1, HOK, 24, 0, 0, 0, ea(0, 0, 0, 24));
    run("R10 misaligned", 3'd0, 0, 3'd3, 1, 2'd1, HOK, 20, 0, 0, 2, '0);
    run("R10 misaligned beats ign", 3'd3, 0, 3'd3, 1, 2'd0, HOK, 20, 60, 0, 2, '0);
    run("R10 clamp high in samples", 3'd0, 0, 3'd3, 1, 2'd1, HOK, 1200, 0, 0, 0, ea(0, 0, 0, 792));
    run("R10 clamp negative", 3'd0, 0, 3'd3, 1, 2'd1, HOK, 32'hFFFF_FFF0, 0, 0, 0, ea(0, 0, 0, 0));
  endtask

  task automatic t_scale();
    run("R9 size4", 3'd0, 0, 3'd4, 0, 2'd1, HOK, 2, 0, 0, 0, ea(0, 0, 0, 32));
    run("R9 size7 as 16", 3'd0, 0, 3'd7, 0, 2'd1, HOK, 2, 0, 0, 0, ea(0, 0, 0, 32));
    run("R11 fmt ignores ba", 3'd0, 1, 3'd0, 1, 2'd1, HOK, 5, 0, 0, 0, ea(0, 0, 0, 20));
    run("R11 fmt ignores size", 3'd0, 1, 3'd4, 0, 2'd1, HOK, 3, 0, 0, 0, ea(0, 0, 0, 12));
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    rsp_ready = 0;
    req_valid = 1; req_dim = 3'd3; req_fmt = 0; req_size = 3'd0; req_byte_addr = 0;
    req_clamp = 2'd1; req_handle = HOK; req_x = 2; req_y = 1; req_z = 0;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    @(posedge clk);
    @(negedge clk);
    check("R1 stall valid", 64'(rsp_valid), 64'd1);
    check("R1 stall ready low", 64'(req_ready), 64'd0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R1 stall hold addr", 64'(rsp_addr), 64'(ea(0, 0, 1, 2)));
    end
    rsp_ready = 1;
    @(negedge clk);
    check("R1 drained", 64'(rsp_valid), 64'd0);
    check("R1 ready back", 64'(req_ready), 64'd1);
  endtask

  initial begin
    rst_n = 0; req_valid = 0; rsp_ready = 1;
    req_x = 0; req_y = 0; req_z = 0; req_dim = 0; req_fmt = 0; req_size = 3'd2;
    req_byte_addr = 0; req_clamp = 2'd1; req_handle = HOK;
    cfg_enable = 1; cfg_max_index = 20'h100; cfg_base = B; cfg_pitch = P;
    cfg_slice_stride = SS; cfg_layer_stride = LS; cfg_width = 100; cfg_height = 50;
    cfg_depth = 8; cfg_layers = 4; cfg_pixel_log2 = 3'd2;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_dims();
    t_layers();
    t_clamp();
    t_handle();
    t_byte_mode();
    t_scale();
    t_backpressure();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule